// File: doc/BRIEF.md
# Reloadable Interval Timer

A 16-bit down-counter paired with a 16-bit reload register, both reached as bytes over a simple read/write register bus with four byte addresses. Software prepares the reload value one byte at a time. Writing the high byte of the counter is the arming event: that byte goes into the reload register, the whole reload value is copied into the counter, and the timer is armed. Each cycle in which the tick-enable input is high takes one step off the count.

When a tick brings the counter to zero, the block sets a sticky interrupt flag and gives a single-cycle request pulse to an interrupt controller. The count carries on through zero to all-ones. In continuous mode the next tick reloads the counter from the reload register, so a period lasts the reload value plus two ticks and the flag is raised on every period. In one-shot mode the counter keeps wrapping downward, and only one flag is raised per arming. Software clears the flag by reading the counter's low byte or by writing either high-byte address.

Top module: `ivt_timer`

## Requirements
- R1: A write to address 0 (counter low) or address 2 (latch low) replaces the low byte of the reload register and leaves the counter unchanged.
- R2: A write to address 1 (counter high) replaces the high byte of the reload register, copies the complete new reload value into the counter at the same edge, clears the flag and arms the timer. In that cycle the load is taken and the tick is not.
- R3: A write to address 3 (latch high) replaces the high byte of the reload register and clears the flag. It does not load the counter.
- R4: In each cycle with `tick_en` high and no load, the counter drops by one, modulo 2^16. While `tick_en` is low the counter holds its value.
- R5: When a tick brings the counter to zero (a decrement from 1, or a reload of a zero value), an armed timer sets `irq_flag` and drives `irq_pulse` high for exactly one cycle. A bus load of zero raises neither.
- R6: With `cont_mode` = 1 (continuous), a tick while the counter is 0xFFFF reloads it from the reload register. A period is therefore reload + 2 ticks, and the flag is raised once per period.
- R7: With `cont_mode` = 0 (one-shot), a tick at 0xFFFF wraps the counter to 0xFFFE, and at most one flag is raised per counter-high write.
- R8: `rdata` is combinational from `addr`: 0 gives the counter low byte, 1 the counter high byte, 2 the reload low byte and 3 the reload high byte. A read of address 0 clears the flag. A read of address 1 leaves the flag unchanged.
- R9: When a flag set and a flag clear fall in the same cycle, the set wins.
- R10: After reset the counter and the reload register both hold 0xFFFF, the timer is armed, and `irq_flag` and `irq_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-step enable, one step per cycle while high |
| cont_mode | input | 1 | 1 = continuous reload, 0 = one-shot |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe; enables the read side effect on flag clearing |
| addr | input | 2 | Byte address (0..3) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| irq_flag | output | 1 | Sticky timer interrupt flag |
| irq_pulse | output | 1 | One-cycle request pulse on each flag event |

## Verification
The bench checks the exact length of a continuous period, reload + 2 ticks. A design that reloaded on zero instead of after 0xFFFF would come back two ticks early. A reload value of zero is tested in continuous mode, and a design that flagged only on a decrement from 1 would never fire there. In one-shot mode the counter is run through a full second wrap to zero with the flag cleared. A design that re-armed on its own would raise a second flag, and one that reloaded would show the wrong count. The bench also confirms that a load wins over a same-cycle tick, that a same-cycle read of the low byte does not swallow a new flag, and that neither low-byte write nor the latch-high write disturbs the running count.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

   typedef enum logic [1:0] {
      IVT_CNT_LO = 2'd0,
      IVT_CNT_HI = 2'd1,
      IVT_LAT_LO = 2'd2,
      IVT_LAT_HI = 2'd3
   } ivt_addr_e;

endpackage

// File: rtl/ivt_latch.sv
module ivt_latch
   import ivt_pkg::*;
#(
   parameter int BUS_W = 8,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       addr,
   input  logic [BUS_W-1:0] wdata,
   output logic [CNT_W-1:0] latch_q,
   output logic [CNT_W-1:0] latch_nxt,
   output logic             load_o,
   output logic             wr_clr_o
);

   localparam int LANES = CNT_W / BUS_W;

   ivt_addr_e a;
   logic      hit_lo;
   logic      hit_hi;

   assign a        = ivt_addr_e'(addr);
   assign hit_lo   = wr_en && (a == IVT_CNT_LO || a == IVT_LAT_LO);
   assign hit_hi   = wr_en && (a == IVT_CNT_HI || a == IVT_LAT_HI);
   assign load_o   = wr_en && (a == IVT_CNT_HI);
   assign wr_clr_o = hit_hi;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [BUS_W-1:0] q;
      logic [BUS_W-1:0] nxt;
      logic             sel;

      assign sel = (g == 0) ? hit_lo : hit_hi;
      assign nxt = sel ? wdata : q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '1;
         else        q <= nxt;
      end

      assign latch_q[g*BUS_W +: BUS_W]   = q;
      assign latch_nxt[g*BUS_W +: BUS_W] = nxt;
   end

endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             load_i,
   input  logic             cont_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic [CNT_W-1:0] reload_val_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             zero_hit_o
);

   localparam logic [CNT_W-1:0] ALL_ONES = '1;
   localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic             step;

   assign step = tick_i && !load_i;

   always_comb begin
      cnt_d = cnt_q;
      if (load_i)
         cnt_d = load_val_i;
      else if (tick_i) begin
         if (cont_i && cnt_q == ALL_ONES) cnt_d = reload_val_i;
         else                             cnt_d = cnt_q - ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= ALL_ONES;
      else        cnt_q <= cnt_d;
   end

   assign cnt_o      = cnt_q;
   assign zero_hit_o = step && (cnt_d == '0);

   AST_DEC_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cnt_q == ONE) |=> (cnt_q == '0));  // R4
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !load_i) |=> $stable(cnt_q));  // R4
   AST_ONESHOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !cont_i && cnt_q == ALL_ONES) |=> (cnt_q == ALL_ONES - ONE));  // R7
   AST_CONT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cont_i && cnt_q == ALL_ONES) |=> (cnt_q == $past(reload_val_i)));  // R6

endmodule

// File: rtl/ivt_flag.sv
module ivt_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic zero_hit_i,
   input  logic arm_i,
   input  logic cont_i,
   input  logic clr_i,
   output logic flag_o,
   output logic pulse_o
);

   logic armed_q;
   logic flag_q;
   logic pulse_q;
   logic fire;

   assign fire = zero_hit_i && (cont_i || armed_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
         flag_q  <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= fire;
         if (fire)       flag_q <= 1'b1;
         else if (clr_i) flag_q <= 1'b0;
         if (arm_i)                armed_q <= 1'b1;
         else if (fire && !cont_i) armed_q <= 1'b0;
      end
   end

   assign flag_o  = flag_q;
   assign pulse_o = pulse_q;

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q);  // R5
   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !zero_hit_i) |=> !flag_q);  // R8
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && fire) |=> flag_q);  // R9
   AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !cont_i && !arm_i) |=> !armed_q);  // R7

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
   import ivt_pkg::*;
#(
   parameter int BUS_W = 8,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             cont_mode,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [1:0]       addr,
   input  logic [BUS_W-1:0] wdata,
   output logic [BUS_W-1:0] rdata,
   output logic             irq_flag,
   output logic             irq_pulse
);

   localparam int HI_LSB = CNT_W - BUS_W;

   if (CNT_W != 2 * BUS_W) begin : g_bad_width
      $error("ivt_timer: CNT_W must be twice BUS_W");
   end
   if (BUS_W < 1) begin : g_bad_bus
      $error("ivt_timer: BUS_W must be positive");
   end

   logic [CNT_W-1:0] latch_q;
   logic [CNT_W-1:0] latch_nxt;
   logic [CNT_W-1:0] cnt;
   logic             load;
   logic             wr_clr;
   logic             rd_clr;
   logic             zero_hit;
   ivt_addr_e        a;

   assign a      = ivt_addr_e'(addr);
   assign rd_clr = rd_en && (a == IVT_CNT_LO);

   ivt_latch #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .addr     (addr),
      .wdata    (wdata),
      .latch_q  (latch_q),
      .latch_nxt(latch_nxt),
      .load_o   (load),
      .wr_clr_o (wr_clr)
   );

   ivt_counter #(.CNT_W(CNT_W)) u_counter (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick_en),
      .load_i      (load),
      .cont_i      (cont_mode),
      .load_val_i  (latch_nxt),
      .reload_val_i(latch_q),
      .cnt_o       (cnt),
      .zero_hit_o  (zero_hit)
   );

   ivt_flag u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .zero_hit_i(zero_hit),
      .arm_i     (load),
      .cont_i    (cont_mode),
      .clr_i     (rd_clr || wr_clr),
      .flag_o    (irq_flag),
      .pulse_o   (irq_pulse)
   );

   always_comb begin
      unique case (a)
         IVT_CNT_LO: rdata = cnt[BUS_W-1:0];
         IVT_CNT_HI: rdata = cnt[HI_LSB +: BUS_W];
         IVT_LAT_LO: rdata = latch_q[BUS_W-1:0];
         default:    rdata = latch_q[HI_LSB +: BUS_W];
      endcase
   end

   AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == latch_q));  // R2
   AST_PULSE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> (cnt == '0));  // R5
   AST_PULSE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> irq_flag);  // R9
   AST_LOWWR_KEEPS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (a == IVT_CNT_LO || a == IVT_LAT_LO) && !tick_en) |=> $stable(cnt));  // R1

endmodule

// File: tb/test_ivt_timer.sv
module test_ivt_timer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       cont_mode = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       irq_flag;
   logic       irq_pulse;

   int  n_run = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #5 clk = ~clk;

   ivt_timer i_ivt_timer (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cont_mode(cont_mode),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .irq_flag(irq_flag), .irq_pulse(irq_pulse)
   );

   task automatic check(string req, string what, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic bus_wr(logic [1:0] a, logic [7:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(logic [1:0] a, output logic [7:0] d);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(posedge clk); @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic peek(logic [1:0] a, output logic [7:0] d);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic peek_cnt(output logic [15:0] c);
      logic [7:0] lo, hi;
      peek(2'd1, hi);
      peek(2'd0, lo);
      c = {hi, lo};
   endtask

   task automatic ticks(int n);
      tick_en = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) begin @(posedge clk); @(negedge clk); end
   endtask

   task automatic load(logic [15:0] v);
      bus_wr(2'd2, v[7:0]);
      bus_wr(2'd1, v[15:8]);
   endtask

   task automatic t_reset;
      logic [7:0] d;
      logic [15:0] c;
      check("R10", "flag after reset", irq_flag, 0);
      check("R10", "pulse after reset", irq_pulse, 0);
      peek_cnt(c);
      check("R10", "counter after reset", c, 16'hFFFF);
      peek(2'd2, d); check("R10", "latch lo after reset", d, 8'hFF);
      peek(2'd3, d); check("R10", "latch hi after reset", d, 8'hFF);
   endtask

   task automatic t_low_writes;
      logic [7:0] d;
      logic [15:0] c;
      load(16'h1234);
      peek_cnt(c); check("R2", "counter after load", c, 16'h1234);
      bus_wr(2'd0, 8'h56);
      peek_cnt(c); check("R1", "counter after cnt-lo write", c, 16'h1234);
      peek(2'd2, d); check("R1", "latch lo after cnt-lo write", d, 8'h56);
      bus_wr(2'd2, 8'h9A);
      peek_cnt(c); check("R1", "counter after latch-lo write", c, 16'h1234);
      peek(2'd2, d); check("R1", "latch lo after latch-lo write", d, 8'h9A);
      peek(2'd3, d); check("R8", "latch hi read", d, 8'h12);
   endtask

   task automatic t_tick_gate;
      logic [15:0] c;
      cont_mode = 1'b0;
      load(16'h0100);
      idle(5);
      peek_cnt(c); check("R4", "counter held with tick low", c, 16'h0100);
      ticks(3);
      peek_cnt(c); check("R4", "counter after 3 ticks", c, 16'h00FD);
   endtask

   task automatic t_oneshot;
      logic [7:0] d;
      logic [15:0] c;
      cont_mode = 1'b0;
      load(16'h0003);
      ticks(2);
      check("R5", "flag before zero", irq_flag, 0);
      ticks(1);
      check("R5", "flag at zero", irq_flag, 1);
      check("R5", "pulse at zero", irq_pulse, 1);
      idle(1);
      check("R5", "pulse one cycle only", irq_pulse, 0);
      bus_rd(2'd1, d);
      check("R8", "flag kept by cnt-hi read", irq_flag, 1);
      ticks(2);
      peek_cnt(c); check("R7", "one-shot wraps past FFFF", c, 16'hFFFE);
      bus_rd(2'd0, d);
      check("R8", "cnt-lo read data", d, 8'hFE);
      check("R8", "flag cleared by cnt-lo read", irq_flag, 0);
      ticks(16'hFFFE);
      peek_cnt(c); check("R7", "counter at second zero", c, 16'h0000);
      check("R7", "no second flag in one-shot", irq_flag, 0);
   endtask

   task automatic t_continuous;
      logic [7:0] d;
      logic [15:0] c;
      cont_mode = 1'b1;
      bus_wr(2'd2, 8'h04);
      bus_wr(2'd3, 8'h00);
      bus_wr(2'd1, 8'h00);
      ticks(4);
      check("R6", "first continuous flag", irq_flag, 1);
      bus_rd(2'd0, d);
      check("R8", "flag cleared by read", irq_flag, 0);
      ticks(1);
      peek_cnt(c); check("R6", "counter passes FFFF", c, 16'hFFFF);
      ticks(1);
      peek_cnt(c); check("R6", "counter reloaded", c, 16'h0004);
      ticks(3);
      check("R6", "no flag before period end", irq_flag, 0);
      ticks(1);
      check("R6", "flag after latch+2 ticks", irq_flag, 1);
      check("R6", "pulse on second period", irq_pulse, 1);
   endtask

   task automatic t_zero_latch;
      logic [15:0] c;
      cont_mode = 1'b1;
      bus_wr(2'd3, 8'h00);
      load(16'h0000);
      check("R5", "bus load of zero does not flag", irq_flag, 0);
      peek_cnt(c); check("R2", "counter loaded with zero", c, 16'h0000);
      ticks(1);
      check("R5", "no flag at FFFF", irq_flag, 0);
      ticks(1);
      check("R5", "flag on reload of zero", irq_flag, 1);
      check("R5", "pulse on reload of zero", irq_pulse, 1);
   endtask

   task automatic t_set_beats_clear;
      logic [7:0] d;
      logic [15:0] c;
      cont_mode = 1'b0;
      load(16'h0002);
      ticks(1);
      tick_en = 1'b1; rd_en = 1'b1; addr = 2'd0;
      #1 d = rdata;
      @(posedge clk); @(negedge clk);
      tick_en = 1'b0; rd_en = 1'b0;
      check("R8", "cnt-lo read data before zero", d, 8'h01);
      check("R9", "set wins over same-cycle read clear", irq_flag, 1);
      bus_wr(2'd3, 8'h77);
      check("R3", "flag cleared by latch-hi write", irq_flag, 0);
      peek_cnt(c); check("R3", "counter kept by latch-hi write", c, 16'h0000);
      peek(2'd3, d); check("R3", "latch hi updated", d, 8'h77);
   endtask

   task automatic t_load_vs_tick;
      logic [15:0] c;
      cont_mode = 1'b0;
      load(16'h0001);
      ticks(1);
      check("R2", "flag set before reload", irq_flag, 1);
      bus_wr(2'd2, 8'h10);
      tick_en = 1'b1;
      bus_wr(2'd1, 8'h00);
      tick_en = 1'b0;
      peek_cnt(c); check("R2", "load wins over tick", c, 16'h0010);
      check("R2", "flag cleared by cnt-hi write", irq_flag, 0);
   endtask

   initial begin
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_low_writes;
      t_tick_gate;
      t_oneshot;
      t_continuous;
      t_zero_latch;
      t_set_beats_clear;
      t_load_vs_tick;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule